// File: doc/BRIEF.md
# Timed Transmit Sample Feeder

This block sits between a set of per-channel transmit sample FIFOs and the inputs of interpolating filters. Each channel has its own feeder. A feeder waits until its FIFO holds a burst. It then holds off until a shared free-running time counter reaches that channel's start time. After that it produces its own sample strobe, once every `rate` clock cycles, and hands one complex sample downstream on each strobe. Each 32-bit FIFO word holds one 16-bit in-phase value and one 16-bit quadrature value.

Every channel has its own rate input, its own start time and its own strobe, so channels start and pace independently. A strobe can fall due while the FIFO is empty. When that happens the channel records a sticky underrun and falls back to idle. The sticky flags of all channels are ORed into one output. An idle indication per channel tells downstream logic that no burst is in flight, for example so it can stuff zeros to flush the filter pipeline.

Each channel is a three-state machine:
- IDLE: nothing queued.
- ARMED: samples are queued but the start time has not been reached.
- STREAM: strobes are being issued.

Transitions:
- IDLE→ARMED when the FIFO becomes non-empty.
- ARMED→STREAM when the start compare passes.
- STREAM→IDLE when a strobe falls due with an empty FIFO.
- Any state→IDLE on a synchronous clear.

Top module: `tx_feed_array`

## Requirements
- R1: In STREAM with samples available, the strobe pulses for one cycle and recurs every `rate` cycles. The first strobe of a burst appears two cycles after the first cycle in which the start compare passes while ARMED.
- R2: A rate value below 4 behaves exactly as a rate of 4. Values up to at least 128 are honoured as given.
- R3: A channel leaves ARMED only once `now_time - start_time`, taken as a signed value of the time counter's width, is zero or positive. A start time lying just past a counter wrap therefore does not start early.
- R4: The FIFO word is popped in the cycle before its strobe. During the strobe cycle, the I output equals word bits [15:0] and the Q output equals word bits [31:16].
- R5: Outside STREAM, the I and Q outputs of a channel are zero and its strobe is low.
- R6: A strobe falling due with an empty FIFO issues no strobe and returns the channel to IDLE. It also sets the sticky underrun flag, which is visible the next cycle and stays set until clear.
- R7: `underrun_any` is high while any channel's sticky underrun flag is set, even while other channels are still streaming.
- R8: `chan_idle` of a channel is high exactly when that channel is in IDLE.
- R9: A cycle with `clear` high returns every channel to IDLE, zeroes its outputs, drops the underrun flags and restarts the rate count. No further strobes follow from the interrupted burst.
- R10: Channels with different rates and start times run concurrently without affecting each other's strobe timing or data.
- R11: The FIFO is never popped while it reports empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear | input | 1 | Synchronous return to idle, clears underrun |
| now_time | input | TIME_W | Free-running global time counter |
| start_time | input | NUM_CH*TIME_W | Per-channel burst start time |
| rate | input | NUM_CH*RATE_W | Per-channel clock cycles per strobe |
| fifo_data | input | NUM_CH*32 | Per-channel show-ahead FIFO head word |
| fifo_empty | input | NUM_CH | Per-channel FIFO empty |
| fifo_rd | output | NUM_CH | Per-channel FIFO pop |
| smp_i | output | NUM_CH*16 | Per-channel in-phase sample |
| smp_q | output | NUM_CH*16 | Per-channel quadrature sample |
| smp_strobe | output | NUM_CH | Per-channel sample strobe |
| chan_idle | output | NUM_CH | Per-channel no burst in flight |
| underrun_any | output | 1 | OR of sticky per-channel underruns |

## Verification
The bench builds the block with two channels, an 8-bit time counter and an 8-bit rate. The narrow counter wraps every 256 cycles. This lets the bench place a start time just beyond the wrap, which a naive unsigned compare would start on at once, and also reach past-due and exactly-due start times. The rate is swept over every clamped value 0 to 3, the floor 4, several odd and even values and 128. Every strobe cycle, popped word, underrun onset and idle return is checked against timing computed from the burst's start cycle and rate.

// File: rtl/tx_feed_pkg.sv
package tx_feed_pkg;

    localparam int SAMPLE_W   = 16;
    localparam int WORD_W     = 2 * SAMPLE_W;
    localparam int RATE_FLOOR = 4;

    typedef enum logic [1:0] {
        FEED_IDLE   = 2'd0,
        FEED_ARMED  = 2'd1,
        FEED_STREAM = 2'd2
    } feed_state_e;

endpackage

// File: rtl/tx_rate_ticker.sv
module tx_rate_ticker
    import tx_feed_pkg::*;
#(
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              run,
    input  logic [RATE_W-1:0] rate_in,
    output logic              tick
);

    localparam logic [RATE_W-1:0] FLOOR = RATE_W'(RATE_FLOOR);

    logic [RATE_W-1:0] rate_eff;
    logic [RATE_W-1:0] cnt_q;

    // values under the floor are raised to it (R2)
    assign rate_eff = (rate_in < FLOOR) ? FLOOR : rate_in;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == '0) begin
            cnt_q <= rate_eff - RATE_W'(1);
        end else begin
            cnt_q <= cnt_q - RATE_W'(1);
        end
    end

    assign tick = run && !clear && (cnt_q == '0);

    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/tx_start_gate.sv
module tx_start_gate #(
    parameter int TIME_W = 32
) (
    input  logic [TIME_W-1:0] now_time,
    input  logic [TIME_W-1:0] start_time,
    output logic              due
);

    logic [TIME_W-1:0] lead;

    // modular difference; sign bit clear means the start time is reached (R3)
    assign lead = now_time - start_time;
    assign due  = ~lead[TIME_W-1];

endmodule

// File: rtl/tx_chan_feeder.sv
module tx_chan_feeder
    import tx_feed_pkg::*;
#(
    parameter int TIME_W = 32,
    parameter int RATE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic [TIME_W-1:0]   now_time,
    input  logic [TIME_W-1:0]   start_time,
    input  logic [RATE_W-1:0]   rate_in,
    input  logic [WORD_W-1:0]   fifo_data,
    input  logic                fifo_empty,
    output logic                fifo_rd,
    output logic [SAMPLE_W-1:0] smp_i,
    output logic [SAMPLE_W-1:0] smp_q,
    output logic                smp_strobe,
    output logic                underrun,
    output logic                chan_idle
);

    feed_state_e state_q;
    feed_state_e state_d;
    logic        due;
    logic        tick;
    logic        starve;

    tx_start_gate #(.TIME_W(TIME_W)) u_gate (
        .now_time   (now_time),
        .start_time (start_time),
        .due        (due)
    );

    tx_rate_ticker #(.RATE_W(RATE_W)) u_ticker (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .run     (state_q == FEED_STREAM),
        .rate_in (rate_in),
        .tick    (tick)
    );

    assign starve  = (state_q == FEED_STREAM) && tick && fifo_empty;
    assign fifo_rd = (state_q == FEED_STREAM) && tick && !fifo_empty;

    always_comb begin
        state_d = state_q;
        if (clear) begin
            state_d = FEED_IDLE;
        end else begin
            unique case (state_q)
                FEED_IDLE:   if (!fifo_empty) state_d = FEED_ARMED;
                FEED_ARMED:  if (due)         state_d = FEED_STREAM;
                FEED_STREAM: if (starve)      state_d = FEED_IDLE;
                default:                      state_d = FEED_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FEED_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            smp_strobe <= 1'b0;
            smp_i      <= '0;
            smp_q      <= '0;
            underrun   <= 1'b0;
        end else begin
            smp_strobe <= fifo_rd;
            if (fifo_rd) begin
                smp_i <= fifo_data[SAMPLE_W-1:0];
                smp_q <= fifo_data[WORD_W-1:SAMPLE_W];
            end else if (state_d != FEED_STREAM) begin
                smp_i <= '0;
                smp_q <= '0;
            end
            if (starve) underrun <= 1'b1;
        end
    end

    assign chan_idle = (state_q == FEED_IDLE);

    assert_hold_until_due_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FEED_ARMED && !due && !clear) |=> (state_q == FEED_ARMED));

    assert_pop_then_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_rd && !clear) |=> (smp_strobe && smp_q == $past(fifo_data[WORD_W-1:SAMPLE_W])));

    assert_quiet_outside_stream_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != FEED_STREAM) |-> (smp_i == '0 && smp_q == '0 && !smp_strobe));

    assert_underrun_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !clear) |=> underrun);

    assert_strobe_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        smp_strobe |=> !smp_strobe);

    assert_clear_idles_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (chan_idle && !underrun && !smp_strobe));

endmodule

// File: rtl/tx_feed_array.sv
module tx_feed_array
    import tx_feed_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int TIME_W = 32,
    parameter int RATE_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic [TIME_W-1:0]          now_time,
    input  logic [NUM_CH*TIME_W-1:0]   start_time,
    input  logic [NUM_CH*RATE_W-1:0]   rate,
    input  logic [NUM_CH*WORD_W-1:0]   fifo_data,
    input  logic [NUM_CH-1:0]          fifo_empty,
    output logic [NUM_CH-1:0]          fifo_rd,
    output logic [NUM_CH*SAMPLE_W-1:0] smp_i,
    output logic [NUM_CH*SAMPLE_W-1:0] smp_q,
    output logic [NUM_CH-1:0]          smp_strobe,
    output logic [NUM_CH-1:0]          chan_idle,
    output logic                       underrun_any
);

    logic [NUM_CH-1:0] underrun_vec;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        tx_chan_feeder #(
            .TIME_W (TIME_W),
            .RATE_W (RATE_W)
        ) u_feed (
            .clk        (clk),
            .rst_n      (rst_n),
            .clear      (clear),
            .now_time   (now_time),
            .start_time (start_time[c*TIME_W +: TIME_W]),
            .rate_in    (rate[c*RATE_W +: RATE_W]),
            .fifo_data  (fifo_data[c*WORD_W +: WORD_W]),
            .fifo_empty (fifo_empty[c]),
            .fifo_rd    (fifo_rd[c]),
            .smp_i      (smp_i[c*SAMPLE_W +: SAMPLE_W]),
            .smp_q      (smp_q[c*SAMPLE_W +: SAMPLE_W]),
            .smp_strobe (smp_strobe[c]),
            .underrun   (underrun_vec[c]),
            .chan_idle  (chan_idle[c])
        );
    end

    assign underrun_any = |underrun_vec;

    assert_pop_only_nonempty_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |=> $past(fifo_empty) == '0 || (($past(fifo_rd) & $past(fifo_empty)) == '0));

endmodule

// File: tb/tx_feed_array_bench.sv
`timescale 1ns/1ps
module tx_feed_array_bench;

    localparam int NCH = 2;
    localparam int TW  = 8;
    localparam int RW  = 8;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic                rst_n;
    logic                clear;
    logic [31:0]         cyc = '0;
    logic [TW-1:0]       now_time;
    logic [NCH*TW-1:0]   start_time;
    logic [NCH*RW-1:0]   rate;
    logic [NCH*32-1:0]   fifo_data;
    logic [NCH-1:0]      fifo_empty;
    logic [NCH-1:0]      fifo_rd;
    logic [NCH*16-1:0]   smp_i;
    logic [NCH*16-1:0]   smp_q;
    logic [NCH-1:0]      smp_strobe;
    logic [NCH-1:0]      chan_idle;
    logic                underrun_any;

    tx_feed_array #(.NUM_CH(NCH), .TIME_W(TW), .RATE_W(RW)) u_tx_feed_array (
        .clk(clk), .rst_n(rst_n), .clear(clear), .now_time(now_time),
        .start_time(start_time), .rate(rate), .fifo_data(fifo_data),
        .fifo_empty(fifo_empty), .fifo_rd(fifo_rd), .smp_i(smp_i),
        .smp_q(smp_q), .smp_strobe(smp_strobe), .chan_idle(chan_idle),
        .underrun_any(underrun_any)
    );

    always @(posedge clk) cyc <= cyc + 32'd1;
    assign now_time = cyc[TW-1:0];

    // show-ahead FIFO model per channel
    logic [31:0] fmem [NCH][64];
    int head [NCH];
    int tail [NCH];
    initial for (int c = 0; c < NCH; c++) begin head[c] = 0; tail[c] = 0; end

    always @(posedge clk)
        for (int c = 0; c < NCH; c++)
            if (fifo_rd[c] && head[c] != tail[c]) head[c] <= head[c] + 1;

    always_comb
        for (int c = 0; c < NCH; c++) begin
            fifo_empty[c]        = (head[c] == tail[c]);
            fifo_data[c*32 +: 32] = fmem[c][head[c] % 64];
        end

    int tests = 0;
    int fails = 0;
    bit finished = 0;
    int exp_first [NCH];
    int exp_rate  [NCH];
    int exp_n     [NCH];
    int seen      [NCH];
    int rd_seen   [NCH];
    logic [31:0] exp_w [NCH][16];

    task automatic check_eq(string req, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mkword(int c, int b, int k);
        logic [31:0] v;
        v = 32'(b) * 32'h0100_0193 + 32'(k) * 32'h9E37_79B1 + 32'(c) * 32'h7F4A_7C15;
        return v;
    endfunction

    // monitor: strobe timing and data (R1, R4, R10), pop timing (R4, R11)
    always @(negedge clk) begin
        if (rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                automatic int k;
                if (fifo_rd[c]) begin
                    k = rd_seen[c];
                    check_eq("R11", "pop while empty", int'(fifo_empty[c]), 0);
                    if (k >= exp_n[c]) check_eq("R4", "unexpected pop", 1, 0);
                    else check_eq("R4", "pop cycle", int'(cyc), exp_first[c] + k*exp_rate[c] - 1);
                    rd_seen[c]++;
                end
                if (smp_strobe[c]) begin
                    k = seen[c];
                    if (k >= exp_n[c]) begin
                        check_eq("R1", "unexpected strobe", 1, 0);
                    end else begin
                        check_eq("R1", "strobe cycle", int'(cyc), exp_first[c] + k*exp_rate[c]);
                        check_eq("R4", "I sample", int'(smp_i[c*16 +: 16]), int'(exp_w[c][k][15:0]));
                        check_eq("R4", "Q sample", int'(smp_q[c*16 +: 16]), int'(exp_w[c][k][31:16]));
                    end
                    seen[c]++;
                end
            end
        end
    end

    task automatic wait_until(int t);
        while (int'(cyc) < t) @(negedge clk);
    endtask

    task automatic pulse_clear();
        @(negedge clk); clear = 1'b1;
        @(negedge clk); clear = 1'b0;
    endtask

    // called at a falling edge: programs a channel and loads n words
    task automatic start_burst(int c, int n, int r_in, int a, int base);
        automatic int r_eff = (r_in < 4) ? 4 : r_in;
        automatic int now = int'(cyc);
        rate[c*RW +: RW]       = RW'(r_in);
        start_time[c*TW +: TW] = TW'(a);
        exp_first[c] = ((a > now + 1) ? a : now + 1) + 2;
        exp_rate[c]  = r_eff;
        exp_n[c]     = n;
        seen[c]      = 0;
        rd_seen[c]   = 0;
        for (int k = 0; k < n; k++) begin
            exp_w[c][k] = mkword(c, base, k);
            fmem[c][(tail[c] + k) % 64] = exp_w[c][k];
        end
        tail[c] = tail[c] + n;
    endtask

    task automatic single_burst(int c, int r_in, int n, int lead, int base);
        automatic int r_eff = (r_in < 4) ? 4 : r_in;
        start_burst(c, n, r_in, int'(cyc) + lead, base);
        @(negedge clk);
        check_eq("R8", "busy after load", int'(chan_idle[c]), 0);
        wait_until(exp_first[c] + n*r_eff - 1);
        check_eq("R6", "no underrun before due", int'(underrun_any), 0);
        @(negedge clk);
        check_eq("R6", "underrun after starve", int'(underrun_any), 1);
        check_eq("R8", "idle after starve", int'(chan_idle[c]), 1);
        check_eq("R1", "strobe count", seen[c], n);
        check_eq("R5", "I zero when idle", int'(smp_i[c*16 +: 16]), 0);
        check_eq("R5", "Q zero when idle", int'(smp_q[c*16 +: 16]), 0);
        @(negedge clk);
        check_eq("R6", "underrun sticky", int'(underrun_any), 1);
        pulse_clear();
        check_eq("R9", "clear drops underrun", int'(underrun_any), 0);
    endtask

    initial begin
        automatic int rates[10] = '{0, 1, 2, 3, 4, 5, 7, 8, 13, 128};
        automatic int c0;
        for (int c = 0; c < NCH; c++) begin
            exp_n[c] = 0; seen[c] = 0; rd_seen[c] = 0; exp_first[c] = 0; exp_rate[c] = 4;
        end
        rst_n = 1'b0; clear = 1'b0; start_time = '0; rate = '0;
        repeat (4) @(negedge clk);
        check_eq("R8", "reset idle", int'(chan_idle), 3);
        check_eq("R5", "reset strobe", int'(smp_strobe), 0);
        check_eq("R5", "reset I", int'(smp_i), 0);
        check_eq("R6", "reset underrun", int'(underrun_any), 0);
        check_eq("R11", "reset pop", int'(fifo_rd), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // rate sweep including clamp (R1, R2) and start leads (R3)
        for (int i = 0; i < 10; i++)
            single_burst(0, rates[i], (rates[i] > 64) ? 2 : 3, 3 + (i % 4), 10 + i);
        for (int i = 0; i < 4; i++)
            single_burst(1, i + 4, 4, 1, 40 + i);

        // start time already passed (R3)
        single_burst(0, 6, 3, -20, 60);

        // start time just beyond the counter wrap (R3)
        while (cyc[TW-1:0] != 8'd235) @(negedge clk);
        single_burst(0, 6, 3, 40, 61);
        while (cyc[TW-1:0] != 8'd250) @(negedge clk);
        single_burst(1, 5, 2, 12, 62);

        // two channels concurrently (R7, R10)
        c0 = int'(cyc);
        start_burst(0, 6, 5, c0 + 10, 70);
        start_burst(1, 4, 9, c0 + 30, 71);
        wait_until(c0 + 50);
        check_eq("R7", "OR flag with one channel starved", int'(underrun_any), 1);
        check_eq("R10", "second channel still streaming", int'(chan_idle[1]), 0);
        wait_until(c0 + 75);
        check_eq("R10", "ch0 strobes", seen[0], 6);
        check_eq("R10", "ch1 strobes", seen[1], 4);
        check_eq("R8", "both idle", int'(chan_idle), 3);
        pulse_clear();
        check_eq("R9", "clear after concurrent", int'(underrun_any), 0);

        // clear during a burst (R9)
        start_burst(1, 5, 6, int'(cyc) + 5, 80);
        wait_until(exp_first[1] + 8);
        clear = 1'b1;
        tail[1] = head[1];
        exp_n[1] = 2;
        @(negedge clk);
        clear = 1'b0;
        repeat (30) @(negedge clk);
        check_eq("R9", "strobes before clear only", seen[1], 2);
        check_eq("R9", "idle after clear", int'(chan_idle[1]), 1);
        check_eq("R9", "no underrun after clear", int'(underrun_any), 0);
        check_eq("R9", "I zero after clear", int'(smp_i[16 +: 16]), 0);
        single_burst(1, 4, 3, 2, 90);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule